// File: doc/BRIEF.md
# Periodic rate generator

This block turns a slow reference time base into a programmable periodic event and a matching square wave. A single-cycle strobe, `base_strobe`, marks every edge of a 32.768 kHz reference, so it arrives 65,536 times per second. A binary prescaler counts these strobes. A 4-bit rate code picks one prescaler stage as the active tap. Code 0 switches everything off. Each higher code halves the rate, so code n gives 2^(16-n) Hz: code 1 gives 32,768 Hz, code 3 gives 8,192 Hz and code 15 gives 2 Hz.

The selected tap has two uses. It raises a one-cycle request, `pf_set`, that a separate flag register captures. It also drives a square-wave pin, which has its own enable. The periodic-interrupt enable does not stop the flag request. It only gates a companion request line, `pirq_req`. The block does not store the flag and does not combine the interrupt sources.

Top module: `pirq_rate_gen`

## Requirements
- R1: While `rst` is high at a rising edge, all three outputs become low, the strobe count clears and the stored rate code becomes 0.
- R2: With rate code 0, `pf_set`, `pirq_req` and `sqw_out` stay low whatever the strobes and enables do.
- R3: With rate code n (1 to 15), `pf_set` pulses for one cycle on every 2^n-th strobe counted since the last restart. This gives 2^(16-n) Hz for 65,536 strobes per second.
- R4: `pf_set` does not depend on `pie_en`. `pirq_req` pulses exactly when `pf_set` pulses and `pie_en` was high at the same edge.
- R5: With `sqw_en` high and code n nonzero, `sqw_out` is low for the first 2^(n-1) strobes of each period and high for the next 2^(n-1). It falls on the strobe that raises `pf_set`, which gives a 50 % duty cycle.
- R6: With `sqw_en` low, `sqw_out` is low after the next edge. The strobe count and `pf_set` are unaffected, so re-enabling resumes at the current phase.
- R7: At an edge where the rate code differs from the stored code, the new code is stored, the count restarts from zero, any strobe at that edge is ignored, and `pf_set` and `sqw_out` are low.
- R8: Edges without a strobe do not advance the count. `pf_set` is low after them and `sqw_out` keeps its value unless an enable or the code changed.
- R9: All outputs are registered. They show the effect of a strobe in the cycle after the rising edge that sampled it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_strobe | input | 1 | One-cycle strobe per edge of the 32.768 kHz reference |
| rate_code | input | 4 | Rate select; 0 = off, n = 2^(16-n) Hz |
| pie_en | input | 1 | Periodic-interrupt enable, gates `pirq_req` only |
| sqw_en | input | 1 | Square-wave output enable |
| pf_set | output | 1 | One-cycle request to set the periodic flag |
| pirq_req | output | 1 | `pf_set` qualified by `pie_en` |
| sqw_out | output | 1 | Square-wave pin |

## Verification
The bench aims at the fastest code, 1, where an off-by-one tap would halve the rate or let the wave stick. It also runs the slowest code, 15, where a short counter would never produce an event. It changes the code with a strobe present at that same edge. A design that did not restart would then emit an early pulse or a shortened wave phase. Toggling `sqw_en` and `pie_en` in the middle of a run exposes two kinds of error: gating applied to the counter instead of the pin, which shifts the phase, and a flag request wrongly suppressed when the enable is low. Runs with idle cycles between strobes catch a design that counts clocks instead of strobes.

// File: rtl/pirq_rate_pkg.sv
package pirq_rate_pkg;
  // Default width of the rate-select code
  parameter int unsigned PIRQ_CODE_W = 4;

  // Number of prescaler stages needed: one per nonzero code
  function automatic int unsigned stage_count(input int unsigned code_w);
    return (1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/pirq_prescaler.sv
// Binary strobe counter; restart clears it and swallows the strobe
module pirq_prescaler #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             adv
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    adv = strobe & ~restart;
    if (restart)
      cnt_nxt = '0;
    else if (strobe)
      cnt_nxt = cnt_q + CNT_W'(1);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pirq_tap_mux.sv
// Selects one prescaler stage per rate code: wrap event and half-period bit
module pirq_tap_mux #(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 15
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              adv,
  output logic              hit,
  output logic              wave
);
  logic [CNT_W:0] wrap_v;
  logic [CNT_W:0] bit_v;

  // Index 0 is the disabled code
  assign wrap_v[0] = 1'b0;
  assign bit_v[0]  = 1'b0;

  for (genvar g = 1; g <= CNT_W; g++) begin : g_tap
    assign wrap_v[g] = (cnt[g-1:0] == '0);
    assign bit_v[g]  = cnt[g-1];
  end

  assign hit  = adv & wrap_v[code];
  assign wave = bit_v[code];
endmodule

// File: rtl/pirq_rate_gen.sv
module pirq_rate_gen
  import pirq_rate_pkg::*;
#(
  parameter int unsigned CODE_W = PIRQ_CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_strobe,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  output logic              pf_set,
  output logic              pirq_req,
  output logic              sqw_out
);
  localparam int unsigned CNT_W = stage_count(CODE_W);

  logic [CODE_W-1:0] code_q;
  logic              restart;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              adv;
  logic              hit;
  logic              wave;

  // A new code restarts the chain so no partial period leaks out
  assign restart = (rate_code != code_q);

  pirq_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .strobe  (base_strobe),
    .restart (restart),
    .cnt_nxt (cnt_nxt),
    .adv     (adv)
  );

  pirq_tap_mux #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_tap (
    .code (rate_code),
    .cnt  (cnt_nxt),
    .adv  (adv),
    .hit  (hit),
    .wave (wave)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q   <= '0;
      pf_set   <= 1'b0;
      pirq_req <= 1'b0;
      sqw_out  <= 1'b0;
    end else begin
      code_q   <= rate_code;
      pf_set   <= hit;
      pirq_req <= hit & pie_en;
      sqw_out  <= wave & sqw_en;
    end
  end
endmodule

// File: rtl/pirq_rate_chk.sv
module pirq_rate_chk #(
  parameter int unsigned CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              base_strobe,
  input logic [CODE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              sqw_en,
  input logic              pf_set,
  input logic              pirq_req,
  input logic              sqw_out
);
  // R3: at least two strobes separate events, so pulses never touch
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    pf_set |=> !pf_set);

  // R8: an event needs a strobe at the preceding edge
  p_pulse_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    pf_set |-> $past(base_strobe));

  // R2: code 0 keeps everything quiet
  p_code0_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rate_code) == '0) |-> (!pf_set && !sqw_out && !pirq_req));

  // R4: the interrupt request follows the flag request
  p_irq_subset_r4: assert property (@(posedge clk) disable iff (rst)
    pirq_req |-> pf_set);

  // R4: an enabled flag request always reaches the interrupt line
  p_irq_when_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    (pf_set && $past(pie_en)) |-> pirq_req);

  // R6: the pin is low after the enable was low
  p_sqw_gated_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!sqw_en) |-> !sqw_out);

  // R7: a code change produces no event and a low pin
  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rate_code) != $past(rate_code, 2)) |-> (!pf_set && !sqw_out));

  // R8: with no strobe and nothing else changing, the pin holds
  p_sqw_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(base_strobe) && ($past(rate_code) == $past(rate_code, 2)) &&
     $past(sqw_en) && $past(sqw_en, 2)) |-> $stable(sqw_out));
endmodule

bind pirq_rate_gen pirq_rate_chk #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .base_strobe (base_strobe),
  .rate_code   (rate_code),
  .pie_en      (pie_en),
  .sqw_en      (sqw_en),
  .pf_set      (pf_set),
  .pirq_req    (pirq_req),
  .sqw_out     (sqw_out)
);

// File: tb/sim_pirq_rate_gen.sv
module sim_pirq_rate_gen;
  localparam int PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       base_strobe = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b1;
  logic       sqw_en = 1'b1;
  logic       pf_set, pirq_req, sqw_out;

  int checks = 0;
  int failures = 0;

  // Reference state derived from the requirements
  int m_code = 0;
  int k = 0;

  pirq_rate_gen u0 (
    .clk(clk), .rst(rst), .base_strobe(base_strobe), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .pf_set(pf_set), .pirq_req(pirq_req),
    .sqw_out(sqw_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One clock with optional strobe; outputs are compared after the edge
  task automatic cyc(input bit s, input string tag);
    bit e_pf, e_sqw, e_irq;
    base_strobe = s;
    @(posedge clk);
    #1;
    base_strobe = 1'b0;
    if (int'(rate_code) != m_code) begin
      m_code = int'(rate_code);
      k = 0;
      e_pf = 1'b0;
      e_sqw = 1'b0;
    end else begin
      if (s) k++;
      e_pf  = s && (m_code != 0) && ((k % (1 << m_code)) == 0);
      e_sqw = sqw_en && (m_code != 0) && (((k >> (m_code - 1)) & 1) == 1);
    end
    e_irq = e_pf && pie_en;
    chk(pf_set == e_pf, tag, "pf_set", int'(pf_set), int'(e_pf));
    chk(pirq_req == e_irq, tag, "pirq_req", int'(pirq_req), int'(e_irq));
    chk(sqw_out == e_sqw, tag, "sqw_out", int'(sqw_out), int'(e_sqw));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rate_code = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    m_code = 0;
    k = 0;
    // R1: all outputs low under reset
    chk(pf_set == 1'b0, "R1", "pf_set", int'(pf_set), 0);
    chk(pirq_req == 1'b0, "R1", "pirq_req", int'(pirq_req), 0);
    chk(sqw_out == 1'b0, "R1", "sqw_out", int'(sqw_out), 0);
    rst = 1'b0;
    cyc(1'b0, "R1");
  endtask

  // R3 / R5 / R8: run a code for n strobes with gap idle clocks after each
  task automatic t_rate(input int code, input int n, input int gap, input string tag);
    rate_code = 4'(code);
    cyc(1'b0, "R7");
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, tag);
      for (int j = 0; j < gap; j++) cyc(1'b0, "R8");
    end
  endtask

  task automatic t_code0();
    int pulses = 0;
    rate_code = 4'd0;
    cyc(1'b0, "R2");
    for (int i = 0; i < 64; i++) begin
      cyc(1'b1, "R2");
      pulses += int'(pf_set) + int'(sqw_out);
    end
    chk(pulses == 0, "R2", "activity with code 0", pulses, 0);
  endtask

  task automatic t_pie();
    int flags = 0;
    pie_en = 1'b0;
    rate_code = 4'd2;
    cyc(1'b0, "R7");
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, "R4");
      flags += int'(pf_set);
    end
    // R4: flag requests still arrive with the enable low (16 strobes / 4)
    chk(flags == 4, "R4", "flag pulses with pie_en low", flags, 4);
    pie_en = 1'b1;
    for (int i = 0; i < 8; i++) cyc(1'b1, "R4");
  endtask

  task automatic t_sqw_gate();
    rate_code = 4'd3;
    cyc(1'b0, "R7");
    for (int i = 0; i < 6; i++) cyc(1'b1, "R5");
    sqw_en = 1'b0;
    for (int i = 0; i < 9; i++) cyc(1'b1, "R6");
    sqw_en = 1'b1;
    for (int i = 0; i < 12; i++) cyc(1'b1, "R6");
  endtask

  task automatic t_change();
    rate_code = 4'd4;
    cyc(1'b0, "R7");
    for (int i = 0; i < 5; i++) cyc(1'b1, "R7");
    // R7: change the code at an edge that also carries a strobe
    rate_code = 4'd2;
    cyc(1'b1, "R7");
    for (int i = 0; i < 10; i++) cyc(1'b1, "R7");
  endtask

  task automatic t_latency();
    rate_code = 4'd1;
    cyc(1'b0, "R7");
    cyc(1'b1, "R9");
    // R9: second strobe raises pf_set right after its edge
    cyc(1'b1, "R9");
    chk(pf_set == 1'b1, "R9", "pf_set after second strobe", int'(pf_set), 1);
    cyc(1'b0, "R9");
    chk(pf_set == 1'b0, "R9", "pf_set one cycle later", int'(pf_set), 0);
  endtask

  task automatic t_slowest();
    int flags = 0;
    rate_code = 4'd15;
    cyc(1'b0, "R7");
    for (int i = 0; i < 32770; i++) begin
      cyc(1'b1, "R3");
      flags += int'(pf_set);
    end
    chk(flags == 1, "R3", "events at code 15", flags, 1);
  endtask

  initial begin
    #(PERIOD * WATCHDOG_CYCLES);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_code0();
    t_rate(1, 12, 0, "R3");
    t_rate(2, 12, 1, "R5");
    t_rate(3, 20, 2, "R3");
    t_rate(5, 70, 0, "R5");
    t_rate(8, 300, 0, "R3");
    t_pie();
    t_sqw_gate();
    t_change();
    t_latency();
    t_slowest();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule